// File: doc/BRIEF.md
# Interval Timer with Programmable Interrupt Vector

The block is a down-counting interval timer that interrupts the processor it serves. Its interrupt request has no fixed interrupt line. Software programs a trap number and a priority, and both go to the interrupt controller alongside a one-cycle request pulse. Software reaches the timer over a single-cycle register bus through three registers:

- a control word holding enable, mode, priority and trap number;
- a reload word that starts a countdown;
- a read-only 32-bit time counter that advances on every tick and never stops.

The build-time parameter `MAP_MODE` picks how the trap and priority become the vector the controller sees:

- **Legacy (0):** the full 8-bit trap number passes through unchanged, and the priority travels beside it on its own output.
- **Current (1):** the vector is placed in the 64–127 interrupt window, and the priority is folded into it.

The `tick_en` input sets the counting rate for both counters.

The countdown is a two-state machine:

- **ST_IDLE:** the timer is not counting.
- **ST_RUN:** the timer counts down on each tick.

Its named transitions are:

- **ARM** (ST_IDLE to ST_RUN): a non-zero reload write while enabled.
- **TICK** (ST_RUN to ST_RUN): a tick decrements the count.
- **RELOAD** (ST_RUN to ST_RUN): expiry in periodic mode fires and refills the count.
- **RESTART** (ST_RUN to ST_RUN): a non-zero reload write during the countdown.
- **EXPIRE** (ST_RUN to ST_IDLE): expiry in one-shot mode fires and stops.
- **DISARM** (ST_RUN to ST_IDLE): a zero reload write.
- **HALT** (ST_RUN to ST_IDLE): enable is found clear.

Top module: `vecirq_timer`

## Requirements
- R1: The control word is at offset 0x0. Its fields are: bit 26 enable, bits 23:20 priority, bits 19:12 trap number, and bit 0 mode (1 = periodic, 0 = one-shot). All other bits read as zero and ignore writes. Reset clears the whole word.
- R2: The reload word is at offset 0x4 and reads back the last value written. The time counter is at offset 0x8. Reads of any other offset return zero, and writes there change nothing. `bus_rdata` is zero unless `bus_sel`=1 and `bus_wr`=0.
- R3: The time counter resets to zero. It adds one at every clock edge where `tick_en`=1 and wraps modulo 2^32. Writes to offset 0x8 are ignored.
- R4: A reload write of N≠0 while enabled arms the countdown (ARM). `irq_req` is high for exactly the one cycle that follows the clock edge at which the N-th subsequent tick is taken.
- R5: In periodic mode, each expiry refills the count from the reload word (RELOAD), so requests recur every N ticks.
- R6: In one-shot mode, expiry returns the timer to ST_IDLE (EXPIRE). No further request comes until the next non-zero reload write.
- R7: A reload write of zero produces no request and leaves the timer in ST_IDLE (DISARM).
- R8: When enable is clear, counting stops (HALT). A request pulse due in the cycle in which enable reads as zero is suppressed. A reload write made while disabled starts nothing, and re-enabling does not resume a halted countdown.
- R9: With MAP_MODE=0, `irq_vector` equals the 8-bit trap field during a request, and `irq_prio` equals the priority field.
- R10: With MAP_MODE=1, `irq_vector` during a request is {2'b01, trap[5:0] OR (priority<<2)}, which always lies in 64–127. `irq_prio` still equals the priority field.
- R11: `irq_vector` and `irq_prio` are zero whenever `irq_req` is low.
- R12: A non-zero reload write during a countdown restarts it from the new value (RESTART). This holds even when the write falls in the cycle of the final tick, and in that case no request is raised.
- R13: While `tick_en`=0, neither the countdown nor the time counter moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counting tick for the countdown and the time counter |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current access |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| irq_vector | output | 8 | Trap number sent with the request |
| irq_prio | output | 4 | Priority sent with the request |

## Verification
The hardest cases to reach are collisions at a single clock edge between a register write and the final tick. Two such collisions matter:

- A control write that clears enable at the very edge where the countdown expires. The pulse is generated there but must not appear.
- A reload write landing on the expiring tick, which must restart the countdown instead of firing.

The stimulus reaches these edges by counting ticks after a known reload write, so the write lands on the exact expiry cycle. A behavioural model then checks every output, for both mapping variants, on every cycle.

// File: rtl/vt_pkg.sv
package vt_pkg;

    localparam int CTRL_EN_BIT    = 26;
    localparam int CTRL_PRIO_LSB  = 20;
    localparam int CTRL_TRAP_LSB  = 12;
    localparam int CTRL_MODE_BIT  = 0;
    localparam int PRIO_W         = 4;
    localparam int TRAP_W         = 8;

    localparam int OFS_CTRL       = 'h0;
    localparam int OFS_RELOAD     = 'h4;
    localparam int OFS_TIME       = 'h8;

    localparam int MAP_LEGACY     = 0;
    localparam int MAP_CURRENT    = 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vt_state_e;

    typedef struct packed {
        logic                en;
        logic [PRIO_W-1:0]   prio;
        logic [TRAP_W-1:0]   trap;
        logic                periodic;
    } vt_ctrl_s;

endpackage

// File: rtl/vt_timebase.sv
module vt_timebase #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [TIME_W-1:0] time_val
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_val <= '0;
        end else if (tick_en) begin
            time_val <= time_val + TIME_W'(1);
        end
    end

    assert_time_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> time_val == $past(time_val) + TIME_W'(1));

    assert_time_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(time_val));

endmodule

// File: rtl/vt_regs.sv
module vt_regs
    import vt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] time_val,
    output vt_ctrl_s          ctrl,
    output logic [DATA_W-1:0] reload_val,
    output logic              load_stb,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_TIME   = ADDR_W'(OFS_TIME);
    localparam logic [DATA_W-1:0] CTRL_MASK =
          (DATA_W'(1) << CTRL_EN_BIT)
        | (DATA_W'((1 << PRIO_W) - 1) << CTRL_PRIO_LSB)
        | (DATA_W'((1 << TRAP_W) - 1) << CTRL_TRAP_LSB)
        | (DATA_W'(1) << CTRL_MODE_BIT);

    logic              wr_access;
    logic              rd_access;
    logic              ctrl_wr;
    logic [DATA_W-1:0] ctrl_word;

    assign wr_access = bus_sel &&  bus_wr;
    assign rd_access = bus_sel && !bus_wr;
    assign ctrl_wr   = wr_access && (bus_addr == A_CTRL);
    assign load_stb  = wr_access && (bus_addr == A_RELOAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.en       <= bus_wdata[CTRL_EN_BIT];
            ctrl.prio     <= bus_wdata[CTRL_PRIO_LSB +: PRIO_W];
            ctrl.trap     <= bus_wdata[CTRL_TRAP_LSB +: TRAP_W];
            ctrl.periodic <= bus_wdata[CTRL_MODE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_val <= '0;
        end else if (load_stb) begin
            reload_val <= bus_wdata;
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_EN_BIT]                   = ctrl.en;
        ctrl_word[CTRL_PRIO_LSB +: PRIO_W]       = ctrl.prio;
        ctrl_word[CTRL_TRAP_LSB +: TRAP_W]       = ctrl.trap;
        ctrl_word[CTRL_MODE_BIT]                 = ctrl.periodic;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_access) begin
            unique case (bus_addr)
                A_CTRL:   bus_rdata = ctrl_word;
                A_RELOAD: bus_rdata = reload_val;
                A_TIME:   bus_rdata = time_val;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assert_ctrl_spare_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_access && bus_addr == A_CTRL) |-> ((bus_rdata & ~CTRL_MASK) == '0));

    assert_idle_bus_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_access |-> bus_rdata == '0);

    assert_time_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_access && bus_addr == A_TIME) |=> $stable(ctrl) && $stable(reload_val));

endmodule

// File: rtl/vt_countdown.sv
module vt_countdown
    import vt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ctrl_en,
    input  logic             periodic,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             fire
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    vt_state_e        st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             fire_nx;

    // next-state and count decisions
    always_comb begin
        st_nx   = st_q;
        cnt_nx  = cnt_q;
        fire_nx = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (load_stb && ctrl_en && load_val != '0) begin   // ARM
                    st_nx  = ST_RUN;
                    cnt_nx = load_val;
                end
            end
            ST_RUN: begin
                if (!ctrl_en) begin                                 // HALT
                    st_nx = ST_IDLE;
                end else if (load_stb) begin
                    if (load_val == '0) begin                       // DISARM
                        st_nx = ST_IDLE;
                    end else begin                                  // RESTART
                        cnt_nx = load_val;
                    end
                end else if (tick_en) begin
                    if (cnt_q == LAST) begin
                        fire_nx = 1'b1;
                        if (periodic) begin                         // RELOAD
                            cnt_nx = reload_val;
                        end else begin                              // EXPIRE
                            st_nx = ST_IDLE;
                        end
                    end else begin                                  // TICK
                        cnt_nx = cnt_q - LAST;
                    end
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire <= 1'b0;
        end else begin
            fire <= fire_nx;
        end
    end

    assert_fire_from_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(st_q == ST_RUN));

    assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && ctrl_en && !load_stb && tick_en && cnt_q == LAST && !periodic)
        |=> (st_q == ST_IDLE && fire));

    assert_zero_reload_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && load_val == '0) |=> (st_q == ST_IDLE && !fire));

    assert_halt_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> st_q == ST_IDLE);

    assert_frozen_no_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && ctrl_en && !load_stb && !tick_en) |=> ($stable(cnt_q) && !fire));

endmodule

// File: rtl/vt_vector_map.sv
module vt_vector_map
    import vt_pkg::*;
#(
    parameter int MAP_MODE = MAP_CURRENT
) (
    input  logic [TRAP_W-1:0] trap,
    input  logic [PRIO_W-1:0] prio,
    output logic [TRAP_W-1:0] vector,
    output logic [PRIO_W-1:0] prio_out
);

    assign prio_out = prio;

    generate
        if (MAP_MODE == MAP_LEGACY) begin : g_legacy
            assign vector = trap;
        end else begin : g_current
            logic [TRAP_W-3:0] low_bits;
            logic [1:0]        unused_trap_hi;
            assign unused_trap_hi = trap[TRAP_W-1 -: 2];
            assign low_bits = trap[TRAP_W-3:0] | {prio, 2'b00};
            assign vector   = {2'b01, low_bits};
        end
    endgenerate

endmodule

// File: rtl/vecirq_timer.sv
module vecirq_timer
    import vt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int MAP_MODE = MAP_CURRENT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req,
    output logic [7:0]        irq_vector,
    output logic [3:0]        irq_prio
);

    vt_ctrl_s          ctrl;
    logic [DATA_W-1:0] reload_val;
    logic [DATA_W-1:0] time_val;
    logic              load_stb;
    logic              fire;
    logic [TRAP_W-1:0] map_vec;
    logic [PRIO_W-1:0] map_prio;

    vt_timebase #(.TIME_W(DATA_W)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .time_val (time_val)
    );

    vt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .time_val   (time_val),
        .ctrl       (ctrl),
        .reload_val (reload_val),
        .load_stb   (load_stb),
        .bus_rdata  (bus_rdata)
    );

    vt_countdown #(.CNT_W(DATA_W)) u_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .ctrl_en    (ctrl.en),
        .periodic   (ctrl.periodic),
        .load_stb   (load_stb),
        .load_val   (bus_wdata),
        .reload_val (reload_val),
        .fire       (fire)
    );

    vt_vector_map #(.MAP_MODE(MAP_MODE)) u_map (
        .trap     (ctrl.trap),
        .prio     (ctrl.prio),
        .vector   (map_vec),
        .prio_out (map_prio)
    );

    // a pulse already in flight is dropped once enable reads clear
    assign irq_req    = fire && ctrl.en;
    assign irq_vector = irq_req ? map_vec  : '0;
    assign irq_prio   = irq_req ? map_prio : '0;

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ctrl.en);

    assert_quiet_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vector == '0 && irq_prio == '0));

    assert_vector_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && MAP_MODE == MAP_CURRENT) |-> irq_vector[7:6] == 2'b01);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !(ctrl.periodic && reload_val == DATA_W'(1))) |=> !irq_req);

endmodule

// File: tb/vecirq_timer_test.sv
module vecirq_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;

    logic [31:0] rdata_c, rdata_l;
    logic        irq_c, irq_l;
    logic [7:0]  vec_c, vec_l;
    logic [3:0]  prio_c, prio_l;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R1";

    // behavioural reference state
    bit          m_en, m_per, m_run, m_fire;
    int unsigned m_prio, m_trap, m_reload, m_cnt, m_time;

    always #2.5 clk = ~clk;

    vecirq_timer #(.MAP_MODE(1)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_c), .irq_req(irq_c), .irq_vector(vec_c), .irq_prio(prio_c)
    );

    vecirq_timer #(.MAP_MODE(0)) uut_leg (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_l), .irq_req(irq_l), .irq_vector(vec_l), .irq_prio(prio_l)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkctrl(input bit en, input int unsigned prio,
                                           input int unsigned trap, input bit per);
        return (32'(en) << 26) | (32'(prio & 15) << 20) | (32'(trap & 255) << 12) | 32'(per);
    endfunction

    function automatic logic [31:0] exp_rdata();
        if (!(bus_sel && !bus_wr)) return 32'h0;
        case (bus_addr)
            4'h0: return mkctrl(m_en, m_prio, m_trap, m_per);
            4'h4: return m_reload;
            4'h8: return m_time;
            default: return 32'h0;
        endcase
    endfunction

    task automatic compare();
        bit          irq_e  = m_fire && m_en;
        int unsigned vc_e   = irq_e ? (64 | ((m_trap & 63) | (m_prio << 2))) : 0;
        int unsigned vl_e   = irq_e ? m_trap : 0;
        int unsigned pr_e   = irq_e ? m_prio : 0;
        string       vreq   = irq_e ? "R10" : "R11";
        string       lreq   = irq_e ? "R9"  : "R11";
        chk(tag,  "irq_req",      32'(irq_c),  32'(irq_e));
        chk(tag,  "irq_req_leg",  32'(irq_l),  32'(irq_e));
        chk(vreq, "irq_vector",   32'(vec_c),  vc_e);
        chk(lreq, "irq_vec_leg",  32'(vec_l),  vl_e);
        chk(vreq, "irq_prio",     32'(prio_c), pr_e);
        chk(lreq, "irq_prio_leg", 32'(prio_l), pr_e);
        chk(tag,  "bus_rdata",    rdata_c,     exp_rdata());
        chk(tag,  "bus_rdata_leg", rdata_l,    exp_rdata());
    endtask

    task automatic model_edge();
        bit          ld = bus_sel && bus_wr && bus_addr == 4'h4;
        bit          cw = bus_sel && bus_wr && bus_addr == 4'h0;
        int unsigned wd = bus_wdata;
        bit          n_fire = 0;
        bit          n_run  = m_run;
        int unsigned n_cnt  = m_cnt;
        if (!m_run) begin
            if (ld && m_en && wd != 0) begin n_run = 1; n_cnt = wd; end
        end else if (!m_en) begin
            n_run = 0;
        end else if (ld) begin
            if (wd == 0) n_run = 0; else n_cnt = wd;
        end else if (tick_en) begin
            if (m_cnt == 1) begin
                n_fire = 1;
                if (m_per) n_cnt = m_reload; else n_run = 0;
            end else begin
                n_cnt = m_cnt - 1;
            end
        end
        if (tick_en) m_time = m_time + 1;
        if (ld) m_reload = wd;
        if (cw) begin
            m_en = wd[26]; m_per = wd[0]; m_prio = (wd >> 20) & 15; m_trap = (wd >> 12) & 255;
        end
        m_run = n_run; m_cnt = n_cnt; m_fire = n_fire;
    endtask

    task automatic step(input bit sel, input bit wr, input logic [3:0] a,
                        input logic [31:0] d, input bit tk);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk;
        #1;
        compare();
        model_edge();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit tk);
        step(1, 1, a, d, tk);
    endtask

    task automatic rd(input logic [3:0] a, input bit tk);
        step(1, 0, a, 32'h0, tk);
    endtask

    task automatic run(input int n, input bit tk);
        for (int i = 0; i < n; i++) step(0, 0, 4'h0, 32'h0, tk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        m_en = 0; m_per = 0; m_run = 0; m_fire = 0;
        m_prio = 0; m_trap = 0; m_reload = 0; m_cnt = 0; m_time = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, field packing, spare bits
        tag = "R1";
        rd(4'h0, 0); rd(4'h4, 0); rd(4'h8, 0);
        wr(4'h0, 32'hFFFF_FFFF, 0); rd(4'h0, 0);
        wr(4'h0, 32'h0000_0000, 0); rd(4'h0, 0);

        // R2: map, unmapped offsets, idle bus
        tag = "R2";
        wr(4'h4, 32'h1234_5678, 0); rd(4'h4, 0);
        wr(4'hC, 32'hFFFF_FFFF, 0); rd(4'hC, 0); rd(4'h2, 0);
        rd(4'h0, 0); step(1, 1, 4'h4, 32'h0, 0); run(2, 0);

        // R3: time counter and write to it
        tag = "R3";
        run(5, 1); rd(4'h8, 0); wr(4'h8, 32'hDEAD_BEEF, 1); rd(4'h8, 1); rd(4'h8, 0);

        // R4 / R6: one-shot countdown
        tag = "R4";
        wr(4'h0, mkctrl(1, 5, 8'hC7, 0), 0);
        wr(4'h4, 32'd5, 0);
        run(8, 1);
        tag = "R6";
        run(10, 1);

        // R13: gated ticks
        tag = "R13";
        wr(4'h4, 32'd4, 0);
        for (int i = 0; i < 14; i++) step(0, 0, 4'h0, 32'h0, (i % 3) == 0);
        rd(4'h8, 0);

        // R5: periodic
        tag = "R5";
        wr(4'h0, mkctrl(1, 9, 8'h3A, 1), 0);
        wr(4'h4, 32'd3, 0);
        run(14, 1);
        wr(4'h4, 32'd1, 1);
        run(4, 1);

        // R12: restart mid-count and on the final tick
        tag = "R12";
        wr(4'h4, 32'd4, 0);
        run(2, 1);
        wr(4'h4, 32'd6, 1);
        run(5, 1);
        wr(4'h4, 32'd2, 1);
        run(6, 1);

        // R7: zero reload
        tag = "R7";
        wr(4'h4, 32'd0, 1);
        run(10, 1);
        rd(4'h4, 0);

        // R8: disable landing on the expiry edge, then no resume
        tag = "R8";
        wr(4'h4, 32'd4, 0);
        run(3, 1);
        wr(4'h0, mkctrl(0, 9, 8'h3A, 1), 1);
        run(8, 1);
        wr(4'h4, 32'd2, 1);
        run(4, 1);
        wr(4'h0, mkctrl(1, 9, 8'h3A, 1), 1);
        run(6, 1);
        wr(4'h4, 32'd2, 1);
        run(5, 1);

        // R9 / R10: vector mapping across field values
        tag = "R10";
        for (int k = 0; k < 8; k++) begin
            wr(4'h0, mkctrl(1, (k * 5) & 15, (k * 37 + 200) & 255, 0), 0);
            wr(4'h4, 32'd1, 0);
            run(3, 1);
        end
        tag = "R9";
        wr(4'h0, mkctrl(1, 15, 8'hFF, 0), 0);
        wr(4'h4, 32'd2, 0);
        run(4, 1);
        wr(4'h0, mkctrl(1, 0, 8'h00, 0), 0);
        wr(4'h4, 32'd1, 0);
        run(3, 1);

        tag = "R3";
        rd(4'h8, 0);
        run(2, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule